// File: doc/BRIEF.md
# Maskable Radio-Status Interrupt Controller

This block collects four receiver events and turns them into one interrupt line. The events are a counter-done pulse, an AFC out-of-range condition, a change in field strength and a change between mono and stereo. Each event sets a sticky flag, and the flags are shown in an identify byte. A mask register lets each source drive the interrupt line or not, and one bit of the same register sets the polarity of that line. A flag does not clear when it is written. It clears as a side effect of reading one of two status registers. The bus decoder outside this block reports those reads as one-cycle strobes.

The block also registers a 3-bit field-strength level and encodes it as a 7-bit thermometer code. It places that code beside the stereo indication in a radio-status byte. Any change of that byte between one clock cycle and the next counts as an event. All inputs are sampled on the rising clock edge, and every registered output, flag and mask changes at that same edge. The interrupt output is combinational from registered state, so it also changes at that edge.

Top module: `radio_irq_ctrl`

## Requirements
- R1: After reset the identify byte is 8'hC0, the radio-status byte is 8'h7F, the interrupt output is 0, the live AFC bit is 0 and all mask bits are 0.
- R2: A high `cnt_done_i` sets the counter flag (identify bit 5) at that edge. A control-status read strobe clears it at the edge it is sampled. A radio-status read strobe leaves it unchanged.
- R3: A rising `afc_oor_i`, meaning high now and low at the previous edge, sets the AFC flag (identify bit 3). A control-status read clears it and a radio-status read does not. `afc_live_o` shows `afc_oor_i` as registered at the last edge.
- R4: A change of the field-strength code or of the stereo bit sets a shared change flag (identify bit 0). A radio-status read clears it and a control-status read does not.
- R5: Radio-status bits 6:0 hold the thermometer code 7'h7F shifted right by the registered level. Level 0 gives 1111111 (weakest) and level 7 gives 0000000 (strongest).
- R6: Radio-status bit 7 holds the registered stereo input (1 = stereo).
- R7: Identify bits 7 and 6 always read 1, and identify bits 4, 2 and 1 always read 0.
- R8: A mask write stores the byte at the edge it is sampled. Mask bit 0 enables the counter source, bit 1 the field-strength source, bit 2 the AFC source and bit 6 the stereo-change source. The interrupt is active while any flag is both set and enabled. Masked events still set their flags.
- R9: Mask bit 3 selects polarity. With 0 the output idles low and goes high when active. With 1 it idles high and goes low when active.
- R10: Mask bits 7, 5 and 4 have no effect on the interrupt output.
- R11: When an event and the read that clears its flag arrive at the same edge, the flag ends up set.
- R12: Applying the same level and stereo value again raises no change event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask register write data |
| cnt_done_i | input | 1 | Counter measurement done pulse |
| afc_oor_i | input | 1 | AFC out-of-range level |
| fs_level_i | input | FS_W (3) | Field-strength level, 0 = weakest |
| stereo_i | input | 1 | Stereo reception indication |
| ctrl_stat_rd_i | input | 1 | Control-status register read strobe |
| radio_stat_rd_i | input | 1 | Radio-status register read strobe |
| irq_o | output | 1 | Interrupt line, programmable polarity |
| irq_id_o | output | 8 | Interrupt identify byte |
| radio_stat_o | output | 2**FS_W (8) | Stereo bit and thermometer field strength |
| afc_live_o | output | 1 | Registered live AFC out-of-range bit |

## Verification
The hardest case to reach from the ports is a flag that is being set and read-cleared at the same edge. A second hard case is a field-strength change and a stereo change that share the one identify bit but are masked separately. These only show up when the strobes and the events line up in a single cycle. Directed steps force each coincidence: a counter pulse together with a control read, and a level change together with a radio read while only the stereo mask is open. A long random run then mixes strobes, mask writes, repeated levels and AFC toggles. This random run compares every output against a bench model after every edge.

// File: rtl/radio_irq_pkg.sv
package radio_irq_pkg;

    // event source index inside the flag bank
    localparam int SRC_CNT   = 0;
    localparam int SRC_AFC   = 1;
    localparam int SRC_FS    = 2;
    localparam int SRC_MS    = 3;
    localparam int NUM_SRC   = 4;

    // mask register bit positions (software visible)
    localparam int MSK_CNT   = 0;
    localparam int MSK_FS    = 1;
    localparam int MSK_AFC   = 2;
    localparam int MSK_POL   = 3;
    localparam int MSK_MS    = 6;

    // identify byte bit positions (software visible)
    localparam int ID_CHG    = 0;
    localparam int ID_AFC    = 3;
    localparam int ID_CNT    = 5;

    // which read strobe clears a source
    typedef enum logic {
        CLR_BY_CTRL  = 1'b0,
        CLR_BY_RADIO = 1'b1
    } clr_grp_e;

    typedef struct packed {
        logic en_ms;
        logic pol_low;
        logic en_afc;
        logic en_fs;
        logic en_cnt;
    } mask_t;

    function automatic clr_grp_e src_clear_group(input int idx);
        return (idx == SRC_FS || idx == SRC_MS) ? CLR_BY_RADIO : CLR_BY_CTRL;
    endfunction

endpackage

// File: rtl/rirq_status_track.sv
module rirq_status_track #(
    parameter int FS_W    = 3,
    localparam int THERM_W = (1 << FS_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FS_W-1:0]    fs_level_i,
    input  logic               stereo_i,
    input  logic               afc_oor_i,
    output logic [THERM_W:0]   status_o,
    output logic               afc_live_o,
    output logic               fs_evt_o,
    output logic               ms_evt_o,
    output logic               afc_evt_o
);

    typedef struct packed {
        logic               stereo;
        logic [THERM_W-1:0] therm;
        logic               afc;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d        = trk_q;
        trk_d.stereo = stereo_i;
        trk_d.therm  = {THERM_W{1'b1}} >> fs_level_i;
        trk_d.afc    = afc_oor_i;
    end

    // events compare the value being registered against the held one
    assign fs_evt_o  = (trk_d.therm != trk_q.therm);
    assign ms_evt_o  = (trk_d.stereo != trk_q.stereo);
    assign afc_evt_o = trk_d.afc & ~trk_q.afc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.stereo <= 1'b0;
            trk_q.therm  <= {THERM_W{1'b1}};
            trk_q.afc    <= 1'b0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign status_o   = {trk_q.stereo, trk_q.therm};
    assign afc_live_o = trk_q.afc;

    AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ((trk_q.therm & (trk_q.therm + 1'b1)) == '0)); // R5

    AST_AFC_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        afc_live_o |-> !afc_evt_o); // R3

endmodule

// File: rtl/rirq_flag_bank.sv
module rirq_flag_bank
    import radio_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               ctrl_rd_i,
    input  logic               radio_rd_i,
    output logic [NUM_SRC-1:0] flags_o,
    output logic [7:0]         id_o
);

    logic [NUM_SRC-1:0] flag_d, flag_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        logic clr_sel;
        always_comb begin
            if (src_clear_group(g) == CLR_BY_RADIO) clr_sel = radio_rd_i;
            else                                    clr_sel = ctrl_rd_i;
            // a new event wins over a clear in the same cycle
            flag_d[g] = (flag_q[g] & ~clr_sel) | set_i[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags_o = flag_q;

    always_comb begin
        id_o          = 8'b1100_0000;
        id_o[ID_CNT]  = flag_q[SRC_CNT];
        id_o[ID_AFC]  = flag_q[SRC_AFC];
        id_o[ID_CHG]  = flag_q[SRC_FS] | flag_q[SRC_MS];
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[SRC_CNT] |=> flags_o[SRC_CNT]); // R11

    AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd_i && !set_i[SRC_AFC]) |=> !flags_o[SRC_AFC]); // R3

    AST_RADIO_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[SRC_CNT] && !ctrl_rd_i) |=> flags_o[SRC_CNT]); // R2

endmodule

// File: rtl/rirq_irq_out.sv
module rirq_irq_out
    import radio_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_wr_i,
    input  logic [7:0]         mask_wdata_i,
    input  logic [NUM_SRC-1:0] flags_i,
    output logic               irq_o,
    output logic               pol_low_o
);

    mask_t mask_d, mask_q;
    logic  unused_rsv;
    logic  any_active;

    assign unused_rsv = ^{mask_wdata_i[7], mask_wdata_i[5], mask_wdata_i[4]};

    always_comb begin
        mask_d = mask_q;
        if (mask_wr_i) begin
            mask_d.en_cnt  = mask_wdata_i[MSK_CNT];
            mask_d.en_fs   = mask_wdata_i[MSK_FS];
            mask_d.en_afc  = mask_wdata_i[MSK_AFC];
            mask_d.pol_low = mask_wdata_i[MSK_POL];
            mask_d.en_ms   = mask_wdata_i[MSK_MS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign any_active = (flags_i[SRC_CNT] & mask_q.en_cnt)
                      | (flags_i[SRC_AFC] & mask_q.en_afc)
                      | (flags_i[SRC_FS]  & mask_q.en_fs)
                      | (flags_i[SRC_MS]  & mask_q.en_ms);

    assign irq_o     = any_active ^ mask_q.pol_low;
    assign pol_low_o = mask_q.pol_low;

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_i == '0) |-> (irq_o == pol_low_o)); // R9

    AST_MASK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_i |=> (pol_low_o == $past(mask_wdata_i[MSK_POL]))); // R8

endmodule

// File: rtl/radio_irq_ctrl.sv
module radio_irq_ctrl
    import radio_irq_pkg::*;
#(
    parameter int FS_W = 3,
    localparam int ST_W = 1 << FS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr_i,
    input  logic [7:0]       mask_wdata_i,
    input  logic             cnt_done_i,
    input  logic             afc_oor_i,
    input  logic [FS_W-1:0]  fs_level_i,
    input  logic             stereo_i,
    input  logic             ctrl_stat_rd_i,
    input  logic             radio_stat_rd_i,
    output logic             irq_o,
    output logic [7:0]       irq_id_o,
    output logic [ST_W-1:0]  radio_stat_o,
    output logic             afc_live_o
);

    logic               fs_evt, ms_evt, afc_evt;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] flags;
    logic               pol_low;

    rirq_status_track #(.FS_W(FS_W)) trk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fs_level_i (fs_level_i),
        .stereo_i   (stereo_i),
        .afc_oor_i  (afc_oor_i),
        .status_o   (radio_stat_o),
        .afc_live_o (afc_live_o),
        .fs_evt_o   (fs_evt),
        .ms_evt_o   (ms_evt),
        .afc_evt_o  (afc_evt)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_CNT] = cnt_done_i;
        set_vec[SRC_AFC] = afc_evt;
        set_vec[SRC_FS]  = fs_evt;
        set_vec[SRC_MS]  = ms_evt;
    end

    rirq_flag_bank flag_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .ctrl_rd_i  (ctrl_stat_rd_i),
        .radio_rd_i (radio_stat_rd_i),
        .flags_o    (flags),
        .id_o       (irq_id_o)
    );

    rirq_irq_out out_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_wr_i    (mask_wr_i),
        .mask_wdata_i (mask_wdata_i),
        .flags_i      (flags),
        .irq_o        (irq_o),
        .pol_low_o    (pol_low)
    );

    AST_ID_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_id_o[7:6] == 2'b11) && (irq_id_o[4] == 1'b0)
        && (irq_id_o[2:1] == 2'b00)); // R7

    AST_CNT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_done_i |=> irq_id_o[ID_CNT]); // R2

    AST_STEREO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (radio_stat_o[ST_W-1] == $past(stereo_i))); // R6

    AST_QUIET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(radio_stat_rd_i) && $stable(radio_stat_o)) |-> !irq_id_o[ID_CHG]); // R4

    AST_IDLE_POL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_id_o == 8'hC0) |-> (irq_o == pol_low)); // R9

endmodule

// File: tb/radio_irq_ctrl_tb.sv
module radio_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_wdata = 8'h00;
    logic       cnt_done = 1'b0;
    logic       afc_oor = 1'b0;
    logic [2:0] fs_level = 3'd0;
    logic       stereo = 1'b0;
    logic       ctrl_rd = 1'b0;
    logic       radio_rd = 1'b0;
    logic       irq;
    logic [7:0] irq_id;
    logic [7:0] radio_stat;
    logic       afc_live;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model state
    logic [7:0] m_rs;
    logic       m_afc;
    logic       m_cnt_f, m_afc_f, m_fs_f, m_ms_f;
    logic [7:0] m_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    radio_irq_ctrl dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .mask_wr_i       (mask_wr),
        .mask_wdata_i    (mask_wdata),
        .cnt_done_i      (cnt_done),
        .afc_oor_i       (afc_oor),
        .fs_level_i      (fs_level),
        .stereo_i        (stereo),
        .ctrl_stat_rd_i  (ctrl_rd),
        .radio_stat_rd_i (radio_rd),
        .irq_o           (irq),
        .irq_id_o        (irq_id),
        .radio_stat_o    (radio_stat),
        .afc_live_o      (afc_live)
    );

    function automatic logic [6:0] exp_therm(input logic [2:0] lvl);
        return 7'h7F >> lvl;
    endfunction

    function automatic logic [7:0] exp_id();
        return {2'b11, m_cnt_f, 1'b0, m_afc_f, 2'b00, m_fs_f | m_ms_f};
    endfunction

    function automatic logic exp_irq();
        logic act;
        act = (m_cnt_f & m_mask[0]) | (m_fs_f & m_mask[1])
            | (m_afc_f & m_mask[2]) | (m_ms_f & m_mask[6]);
        return act ^ m_mask[3];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_rs = 8'h7F; m_afc = 1'b0; m_mask = 8'h00;
        m_cnt_f = 1'b0; m_afc_f = 1'b0; m_fs_f = 1'b0; m_ms_f = 1'b0;
    endtask

    task automatic model_edge();
        logic [7:0] rs_new;
        logic fs_ev, ms_ev, afc_ev;
        rs_new = {stereo, exp_therm(fs_level)};
        fs_ev  = (rs_new[6:0] != m_rs[6:0]);
        ms_ev  = (rs_new[7] != m_rs[7]);
        afc_ev = afc_oor & ~m_afc;
        m_cnt_f = (m_cnt_f & ~ctrl_rd)  | cnt_done;
        m_afc_f = (m_afc_f & ~ctrl_rd)  | afc_ev;
        m_fs_f  = (m_fs_f  & ~radio_rd) | fs_ev;
        m_ms_f  = (m_ms_f  & ~radio_rd) | ms_ev;
        m_rs  = rs_new;
        m_afc = afc_oor;
        if (mask_wr) m_mask = mask_wdata;
    endtask

    task automatic compare_all();
        chk("R2 counter flag", {7'd0, irq_id[5]}, {7'd0, m_cnt_f});
        chk("R3 afc flag", {7'd0, irq_id[3]}, {7'd0, m_afc_f});
        chk("R3 afc live", {7'd0, afc_live}, {7'd0, m_afc});
        chk("R4 change flag", {7'd0, irq_id[0]}, {7'd0, m_fs_f | m_ms_f});
        chk("R5 thermometer", {1'b0, radio_stat[6:0]}, {1'b0, m_rs[6:0]});
        chk("R6 stereo bit", {7'd0, radio_stat[7]}, {7'd0, m_rs[7]});
        chk("R7 identify reserved", irq_id & 8'hD6, 8'hC0);
        chk("R8 interrupt level", {7'd0, irq}, {7'd0, exp_irq()});
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        mask_wr = 1'b0; cnt_done = 1'b0; ctrl_rd = 1'b0; radio_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 identify", irq_id, 8'hC0);
        chk("R1 radio status", radio_stat, 8'h7F);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 afc live", {7'd0, afc_live}, 8'h00);
        rst_n = 1'b1;
        step();

        // R5: level sweep
        for (int l = 0; l < 8; l++) begin
            fs_level = 3'(l);
            radio_rd = 1'b1;
            step();
            chk("R5 sweep code", {1'b0, radio_stat[6:0]}, {1'b0, 7'h7F >> l});
        end

        // R12: same values again, after clearing
        radio_rd = 1'b1; step();
        step();
        chk("R12 no event on repeat", {7'd0, irq_id[0]}, 8'h00);

        // R2 and R11: counter set and control read in one cycle
        cnt_done = 1'b1; step();
        radio_rd = 1'b1; step();
        chk("R2 radio read keeps counter flag", {7'd0, irq_id[5]}, 8'h01);
        cnt_done = 1'b1; ctrl_rd = 1'b1; step();
        chk("R11 set wins over clear", {7'd0, irq_id[5]}, 8'h01);
        ctrl_rd = 1'b1; step();
        chk("R2 control read clears", {7'd0, irq_id[5]}, 8'h00);

        // R3: AFC edge, held level does not re-raise
        afc_oor = 1'b1; step();
        chk("R3 afc rise sets", {7'd0, irq_id[3]}, 8'h01);
        ctrl_rd = 1'b1; step();
        chk("R3 held level no re-raise", {7'd0, irq_id[3]}, 8'h00);
        afc_oor = 1'b0; step();

        // R8/R4: stereo change with only stereo mask open
        mask_wdata = 8'h40; mask_wr = 1'b1; step();
        fs_level = 3'd2; step();
        chk("R8 masked fs source quiet", {7'd0, irq}, 8'h00);
        chk("R4 masked event still latched", {7'd0, irq_id[0]}, 8'h01);
        radio_rd = 1'b1; stereo = 1'b1; step();
        chk("R8 stereo source active", {7'd0, irq}, 8'h01);
        ctrl_rd = 1'b1; step();
        chk("R4 control read keeps change flag", {7'd0, irq_id[0]}, 8'h01);
        radio_rd = 1'b1; step();

        // R10: reserved mask bits only
        cnt_done = 1'b1; mask_wdata = 8'hB0; mask_wr = 1'b1; step();
        chk("R10 reserved mask bits inert", {7'd0, irq}, 8'h00);

        // R9: active-low polarity
        mask_wdata = 8'h08; mask_wr = 1'b1; step();
        chk("R9 masked pending idles high", {7'd0, irq}, 8'h01);
        mask_wdata = 8'h09; mask_wr = 1'b1; step();
        chk("R9 active low asserted", {7'd0, irq}, 8'h00);
        ctrl_rd = 1'b1; step();
        chk("R9 active low released", {7'd0, irq}, 8'h01);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            cnt_done = ($urandom_range(7) == 0);
            if ($urandom_range(7) == 0) afc_oor = ~afc_oor;
            if ($urandom_range(5) == 0) fs_level = 3'($urandom_range(7));
            if ($urandom_range(9) == 0) stereo = ~stereo;
            ctrl_rd  = ($urandom_range(3) == 0);
            radio_rd = ($urandom_range(3) == 0);
            if ($urandom_range(15) == 0) begin
                mask_wr = 1'b1;
                mask_wdata = 8'($urandom_range(255));
            end
            step();
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule